// File: doc/BRIEF.md
# Four-Channel Shadowed Configuration Register Bank

This block holds the configuration of a four-channel converter behind a plain address/data port with 16-bit addresses and 8-bit data. Some registers exist once for the whole chip. Others exist once per channel. A channel-select mask decides which channel copies a write to a per-channel register reaches.

Every write lands in a master (staging) copy. The decoded per-channel outputs come from a separate active copy. The active copy changes only when software writes a transfer command. That command loads all masters into the active copies at one clock edge, so the settings of all channels change together.

The block also returns a fixed chip identifier and a speed-grade code, which cannot be written. It offers a soft reset that returns every register to its default.

Top module: `chcfg_bank`

## Requirements
- R1: After reset the registers read back as follows.
  - 0x0000 reads 0x18.
  - 0x0005 reads 0x0F.
  - 0x0009 reads 0x01.
  - 0x00FF reads 0x00.
  - 0x0008, 0x000D and 0x000E read 0x00.
  - The outputs come up with every channel in run mode (code 00), no test pattern, self-test off and the duty-cycle stabiliser on.
- R2: Address 0x0001 reads 0x0B, the chip identifier.
- R2 (continued): Address 0x0002 reads the 3-bit grade code in bits 6:4, which gives 0x50 for the default code 101.
- R2 (continued): Writes to 0x0001 and 0x0002 change nothing.
- R3: A write to a per-channel register (0x0008, 0x000D, 0x000E) updates the master copy of channel n only when bit n of the mask at 0x0005 is set. Bit 0 selects channel A and bit 3 selects channel D. A mask of zero updates no channel.
- R4: The outputs reflect only the active copies. Writes to 0x0008, 0x0009, 0x000D or 0x000E leave the outputs unchanged until a transfer occurs.
- R5: Writing 0x00FF with bit 0 set copies every master into its active copy on the next clock edge after the write edge. The transfer bit then clears itself and reads back 0.
- R6: A read of a per-channel register returns the master value of the lowest-numbered channel selected in the mask. It returns 0x00 when the mask is zero.
- R7: A read of any unmapped address returns 0x00. This includes addresses whose upper byte is non-zero.
- R8: Writing 0x0000 with bit 5 set restores every master, active copy, the mask and the port configuration to their defaults at that clock edge. Bit 5 never reads back as 1.
- R9: Field layout.
  - 0x0008 bits 1:0 hold the power mode (00 run, 01 full power-down, 10 standby, 11 reset).
  - 0x000D bits 3:0 hold the test-pattern code.
  - 0x000E bit 0 starts the self-test.
  - 0x0009 bit 0 enables the stabiliser.
  - Unused bits of these registers read 0.
  - Channel n drives chPwrMode[2n+1:2n], chTestMode[4n+3:4n] and chBistGo[n].
  - 0x0000 stores all bits except bit 5.
- R10: rdValid is high exactly one cycle after a cycle with rdEn high. rdData then holds the value of the addressed register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 16 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid |
| chPwrMode | output | 8 | Active power mode, 2 bits per channel |
| chTestMode | output | 16 | Active test-pattern code, 4 bits per channel |
| chBistGo | output | 4 | Active self-test start, 1 bit per channel |
| dutyStabOn | output | 1 | Active duty-cycle stabiliser enable |

## Verification
The bench stages different values into different channels under partial masks. It then checks that the outputs hold still until the transfer, and that they change at exactly one edge afterwards. A design that updated the active copy directly, or copied at the write edge itself, would show the new values one check too early.

Reads under a two-channel mask and under an empty mask expose a wrong lowest-channel choice or a missing zero case. A write under an empty mask exposes a bank that ignores the mask.

Writes to the identifier registers, reads of addresses with a non-zero upper byte, and a soft reset issued after staged and transferred values catch the following faults:
- writable constants;
- partial address decoding;
- a reset that misses the active copies.

// File: rtl/chcfg_pkg.sv
package chcfg_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_PORT  = 16'h0000;
  localparam logic [ADDR_W-1:0] A_ID    = 16'h0001;
  localparam logic [ADDR_W-1:0] A_GRADE = 16'h0002;
  localparam logic [ADDR_W-1:0] A_MASK  = 16'h0005;
  localparam logic [ADDR_W-1:0] A_MODE  = 16'h0008;
  localparam logic [ADDR_W-1:0] A_CLK   = 16'h0009;
  localparam logic [ADDR_W-1:0] A_TEST  = 16'h000D;
  localparam logic [ADDR_W-1:0] A_BIST  = 16'h000E;
  localparam logic [ADDR_W-1:0] A_XFER  = 16'h00FF;

  localparam logic [DATA_W-1:0] PORT_DFLT = 8'h18;
  localparam int SRST_BIT = 5;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PORT, SEL_ID, SEL_GRADE, SEL_MASK,
    SEL_MODE, SEL_CLK, SEL_TEST, SEL_BIST, SEL_XFER
  } rdsel_t;

  typedef struct packed {
    logic wrPort;
    logic wrMask;
    logic wrMode;
    logic wrClk;
    logic wrTest;
    logic wrBist;
    logic softRst;
    logic copyNow;
    logic rdTake;
  } strobe_t;
endpackage

// File: rtl/chcfg_ctrl.sv
module chcfg_ctrl
  import chcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strb,
  output rdsel_t            rdSel,
  output logic              xferPend,
  output logic              rdValid
);
  rdsel_t sel;

  // full 16-bit compare: no aliasing of upper address bits
  always_comb begin
    case (addr)
      A_PORT:  sel = SEL_PORT;
      A_ID:    sel = SEL_ID;
      A_GRADE: sel = SEL_GRADE;
      A_MASK:  sel = SEL_MASK;
      A_MODE:  sel = SEL_MODE;
      A_CLK:   sel = SEL_CLK;
      A_TEST:  sel = SEL_TEST;
      A_BIST:  sel = SEL_BIST;
      A_XFER:  sel = SEL_XFER;
      default: sel = SEL_NONE;
    endcase
  end

  assign rdSel = sel;

  logic portHit, xferSet;
  assign portHit = wrEn && (sel == SEL_PORT);
  assign xferSet = wrEn && (sel == SEL_XFER) && wrData[0];

  always_comb begin
    strb         = '0;
    strb.softRst = portHit && wrData[SRST_BIT];
    strb.wrPort  = portHit && !wrData[SRST_BIT];
    strb.wrMask  = wrEn && (sel == SEL_MASK);
    strb.wrMode  = wrEn && (sel == SEL_MODE);
    strb.wrClk   = wrEn && (sel == SEL_CLK);
    strb.wrTest  = wrEn && (sel == SEL_TEST);
    strb.wrBist  = wrEn && (sel == SEL_BIST);
    strb.copyNow = xferPend;
    strb.rdTake  = rdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferPend <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      xferPend <= xferSet && !strb.softRst;
      rdValid  <= rdEn;
    end
  end
endmodule

// File: rtl/chcfg_data.sv
module chcfg_data
  import chcfg_pkg::*;
#(
  parameter int          NUM_CH     = 4,
  parameter logic [7:0]  CHIP_ID    = 8'h0B,
  parameter logic [2:0]  GRADE_CODE = 3'b101
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  rdsel_t              rdSel,
  input  logic                xferPend,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_CH*2-1:0] chPwrMode,
  output logic [NUM_CH*4-1:0] chTestMode,
  output logic [NUM_CH-1:0]   chBistGo,
  output logic                dutyStabOn
);
  localparam int PAD_W = DATA_W - NUM_CH;
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [DATA_W-1:0]   portCfg;
  logic [NUM_CH-1:0]   chanMask;
  logic                dcsM, dcsS;
  logic [NUM_CH*2-1:0] modeM, modeS;
  logic [NUM_CH*4-1:0] testM, testS;
  logic [NUM_CH-1:0]   bistM, bistS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portCfg  <= PORT_DFLT;
      chanMask <= '1;
      dcsM <= 1'b1;  dcsS <= 1'b1;
      modeM <= '0;   modeS <= '0;
      testM <= '0;   testS <= '0;
      bistM <= '0;   bistS <= '0;
    end else if (strb.softRst) begin
      portCfg  <= PORT_DFLT;
      chanMask <= '1;
      dcsM <= 1'b1;  dcsS <= 1'b1;
      modeM <= '0;   modeS <= '0;
      testM <= '0;   testS <= '0;
      bistM <= '0;   bistS <= '0;
    end else begin
      if (strb.wrPort) portCfg  <= wrData;
      if (strb.wrMask) chanMask <= wrData[NUM_CH-1:0];
      if (strb.wrClk)  dcsM     <= wrData[0];
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (chanMask[ch]) begin
          if (strb.wrMode) modeM[ch*2 +: 2] <= wrData[1:0];
          if (strb.wrTest) testM[ch*4 +: 4] <= wrData[3:0];
          if (strb.wrBist) bistM[ch]        <= wrData[0];
        end
      end
      if (strb.copyNow) begin
        dcsS  <= dcsM;
        modeS <= modeM;
        testS <= testM;
        bistS <= bistM;
      end
    end
  end

  // lowest selected channel feeds per-channel reads
  logic [IDX_W-1:0] leadCh;
  logic             anySel;
  always_comb begin
    leadCh = '0;
    anySel = 1'b0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (chanMask[ch]) begin
        leadCh = IDX_W'(ch);
        anySel = 1'b1;
      end
    end
  end

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    rdNext = '0;
    case (rdSel)
      SEL_PORT:  rdNext = portCfg;
      SEL_ID:    rdNext = CHIP_ID;
      SEL_GRADE: rdNext = {1'b0, GRADE_CODE, 4'b0000};
      SEL_MASK:  rdNext = {{PAD_W{1'b0}}, chanMask};
      SEL_CLK:   rdNext = {7'b0, dcsM};
      SEL_XFER:  rdNext = {7'b0, xferPend};
      SEL_MODE:  if (anySel) rdNext = {6'b0, modeM[leadCh*2 +: 2]};
      SEL_TEST:  if (anySel) rdNext = {4'b0, testM[leadCh*4 +: 4]};
      SEL_BIST:  if (anySel) rdNext = {7'b0, bistM[leadCh]};
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdTake) rdData <= rdNext;
  end

  assign chPwrMode  = modeS;
  assign chTestMode = testS;
  assign chBistGo   = bistS;
  assign dutyStabOn = dcsS;
endmodule

// File: rtl/chcfg_bank.sv
module chcfg_bank
  import chcfg_pkg::*;
#(
  parameter int         NUM_CH     = 4,
  parameter logic [7:0] CHIP_ID    = 8'h0B,
  parameter logic [2:0] GRADE_CODE = 3'b101
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic [NUM_CH*2-1:0] chPwrMode,
  output logic [NUM_CH*4-1:0] chTestMode,
  output logic [NUM_CH-1:0]   chBistGo,
  output logic                dutyStabOn
);
  strobe_t strb;
  rdsel_t  rdSel;
  logic    xferPend;

  chcfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .strb(strb), .rdSel(rdSel), .xferPend(xferPend),
    .rdValid(rdValid)
  );

  chcfg_data #(.NUM_CH(NUM_CH), .CHIP_ID(CHIP_ID), .GRADE_CODE(GRADE_CODE)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel), .xferPend(xferPend),
    .wrData(wrData), .rdData(rdData), .chPwrMode(chPwrMode),
    .chTestMode(chTestMode), .chBistGo(chBistGo), .dutyStabOn(dutyStabOn)
  );
endmodule

// File: rtl/chcfg_bank_chk.sv
module chcfg_bank_chk
  import chcfg_pkg::*;
#(
  parameter int         NUM_CH  = 4,
  parameter logic [7:0] CHIP_ID = 8'h0B
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wrData,
  input logic [DATA_W-1:0]   rdData,
  input logic                rdValid,
  input logic [NUM_CH*2-1:0] chPwrMode,
  input logic [NUM_CH*4-1:0] chTestMode,
  input logic [NUM_CH-1:0]   chBistGo,
  input logic                dutyStabOn,
  input strobe_t             strb
);
  logic xferWr, srstWr;
  assign xferWr = wrEn && (addr == A_XFER) && wrData[0];
  assign srstWr = wrEn && (addr == A_PORT) && wrData[SRST_BIT];

  a_r4_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.copyNow && !strb.softRst) |=>
      ($stable(chPwrMode) && $stable(chTestMode) && $stable(chBistGo) && $stable(dutyStabOn)));

  a_r5_copy_follows: assert property (@(posedge clk) disable iff (!rstN)
    (xferWr && !srstWr) |=> strb.copyNow);

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.copyNow && !xferWr) |=> !strb.copyNow);

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    srstWr |=> (chPwrMode == '0 && chTestMode == '0 && chBistGo == '0 && dutyStabOn));

  a_r2_chip_id: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == A_ID) |=> (rdData == CHIP_ID));

  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r10_valid_fall: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
endmodule

bind chcfg_bank chcfg_bank_chk #(.NUM_CH(NUM_CH), .CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .rdValid(rdValid), .chPwrMode(chPwrMode),
  .chTestMode(chTestMode), .chBistGo(chBistGo), .dutyStabOn(dutyStabOn),
  .strb(strb)
);

// File: tb/tb_chcfg_bank.sv
`timescale 1ns/1ps
module tb_chcfg_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [7:0]  chPwrMode;
  logic [15:0] chTestMode;
  logic [3:0]  chBistGo;
  logic        dutyStabOn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  chcfg_bank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .chPwrMode(chPwrMode), .chTestMode(chTestMode), .chBistGo(chBistGo),
    .dutyStabOn(dutyStabOn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected read values as the design returns them
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk("R10 unexpected rdValid", 32'(rdValid), 32'h0);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(t, 32'(rdData), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrapUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pwr mode reset", 32'(chPwrMode), 32'h00);
    chk("R1 test mode reset", 32'(chTestMode), 32'h0000);
    chk("R1 bist reset", 32'(chBistGo), 32'h0);
    chk("R1 stabiliser reset", 32'(dutyStabOn), 32'h1);
    chk("R10 rdValid idle", 32'(rdValid), 32'h0);
    rd(16'h0000, 8'h18, "R1 port cfg default");
    rd(16'h0005, 8'h0F, "R1 mask default");
    rd(16'h0009, 8'h01, "R1 clock reg default");
    rd(16'h00FF, 8'h00, "R1 xfer default");
    rd(16'h0008, 8'h00, "R1 mode default");
    rd(16'h000D, 8'h00, "R1 test default");
    rd(16'h000E, 8'h00, "R1 bist default");

    // R2 read-only identification
    rd(16'h0001, 8'h0B, "R2 chip id");
    rd(16'h0002, 8'h50, "R2 grade");
    wr(16'h0001, 8'hFF);
    wr(16'h0002, 8'hFF);
    rd(16'h0001, 8'h0B, "R2 chip id after write");
    rd(16'h0002, 8'h50, "R2 grade after write");

    // R7 unmapped
    rd(16'h0003, 8'h00, "R7 unmapped 0x0003");
    rd(16'h0010, 8'h00, "R7 unmapped 0x0010");
    rd(16'h0108, 8'h00, "R7 upper byte alias");

    // R10 read latency
    @(negedge clk);
    addr = 16'h0005; rdEn = 1'b1;
    expQ.push_back(8'h0F); tagQ.push_back("R10 latency data");
    chk("R10 no valid before edge", 32'(rdValid), 32'h0);
    @(negedge clk);
    chk("R10 valid one edge later", 32'(rdValid), 32'h1);
    rdEn = 1'b0;

    // R3/R6 masked staging
    wr(16'h0005, 8'h02);
    wr(16'h0008, 8'h01);
    rd(16'h0008, 8'h01, "R3 channel B staged");
    chk("R4 outputs unchanged by staging", 32'(chPwrMode), 32'h00);
    wr(16'h0005, 8'h01);
    rd(16'h0008, 8'h00, "R3 channel A untouched");
    wr(16'h0005, 8'h0C);
    wr(16'h000D, 8'h05);
    wr(16'h000E, 8'h01);
    wr(16'h0008, 8'hFE);
    rd(16'h0008, 8'h02, "R9 mode field bits 1:0");
    rd(16'h000D, 8'h05, "R6 lowest of C and D");
    rd(16'h000E, 8'h01, "R9 bist field");
    wr(16'h0009, 8'hFE);
    rd(16'h0009, 8'h00, "R9 clock field bit 0");
    chk("R4 stabiliser held", 32'(dutyStabOn), 32'h1);
    chk("R4 test held", 32'(chTestMode), 32'h0000);

    // R5 transfer
    wr(16'h00FF, 8'h01);
    chk("R5 no copy at write edge", 32'(chPwrMode), 32'h00);
    @(negedge clk);
    chk("R5 pwr after copy", 32'(chPwrMode), 32'hA4);
    chk("R5 test after copy", 32'(chTestMode), 32'h5500);
    chk("R5 bist after copy", 32'(chBistGo), 32'hC);
    chk("R5 stabiliser after copy", 32'(dutyStabOn), 32'h0);
    rd(16'h00FF, 8'h00, "R5 xfer self clear");

    // R6 empty mask, R3 write under empty mask
    wr(16'h0005, 8'h00);
    rd(16'h0008, 8'h00, "R6 empty mask read");
    wr(16'h0008, 8'h03);
    wr(16'h0005, 8'h0F);
    rd(16'h0008, 8'h00, "R3 empty mask write dropped");
    wr(16'h0005, 8'h08);
    rd(16'h0008, 8'h02, "R3 channel D kept");

    // R8 soft reset
    wr(16'h0000, 8'h3C);
    chk("R8 pwr defaults", 32'(chPwrMode), 32'h00);
    chk("R8 test defaults", 32'(chTestMode), 32'h0000);
    chk("R8 bist defaults", 32'(chBistGo), 32'h0);
    chk("R8 stabiliser default", 32'(dutyStabOn), 32'h1);
    rd(16'h0000, 8'h18, "R8 port cfg default");
    rd(16'h0005, 8'h0F, "R8 mask default");
    rd(16'h0008, 8'h00, "R8 master cleared");
    rd(16'h0009, 8'h01, "R8 clock master default");

    // R9 port config storage
    wr(16'h0000, 8'h58);
    rd(16'h0000, 8'h58, "R9 port cfg stored");

    repeat (3) @(negedge clk);
    chk("R10 all reads returned", 32'(expQ.size()), 32'h0);
    wrapUp();
  end
endmodule